// File: doc/BRIEF.md
# Four-Lane Serial Pixel Word Deserializer

This block takes serial pixel data from up to four detector chips that are read out together. Each chip drives one data lane, and every lane is sampled on the same shift strobe. Each lane shifts its bits into its own 8-bit segment. After eight strobes, the four segments together form one 32-bit word in which the chips' bytes are interleaved. The word is handed to a small FIFO of latched words. A host processor drains the FIFO over a 32-bit parallel read port, so it can fall behind the serial stream for a short time without losing data.

A per-lane enable mask lets an assembly with fewer than four chips leave unused lanes at zero. All lanes still advance in step. When a finished word finds the FIFO full, the word is dropped and a sticky overflow flag is raised until the host clears it. A word counter tracks progress through a frame against a programmable word total. It pulses a frame-done strobe and advances a frame counter each time that total is reached. A full chip frame is 917512 shift strobes, so the counters are sized for frames of that length.

Top module: `pix_lane_deser`

## Requirements
- R1: While reset is high and on the first cycle after it: fifo_empty is 1, ovf_flag is 0, frame_done is 0, word_count and frame_count are 0, and rd_data is 0.
- R2: Lane k fills bits [8k+7:8k] of the word. The first bit received on a lane ends up in the most significant bit of its segment.
- R3: A lane whose lane_mask bit is 0 contributes zeros to its segment. Unmasked lanes are assembled normally on the same strobes.
- R4: Only cycles with shift_en high count as bits; idle cycles hold the partial word. A word is written to the FIFO on the clock edge after the edge that samples its eighth bit. fifo_empty is therefore still 1 after that eighth edge and goes to 0 after the next one.
- R5: The FIFO holds DEPTH words (16 by default) and returns them in the order they were assembled.
- R6: A read (rd_en high while fifo_empty is 0) places the oldest word on rd_data after one clock edge. rd_en while the FIFO is empty leaves rd_data unchanged.
- R7: A word that completes while the FIFO is full is dropped and sets ovf_flag. The words already stored are unchanged, and the flag stays set through later reads.
- R8: ovf_clear high for one cycle clears ovf_flag. If a drop happens in the same cycle, the flag stays set.
- R9: word_count counts assembled words, including dropped ones. When it would reach a nonzero frame_words, it returns to 0, frame_done pulses for one cycle and frame_count increments. A frame_words value of 0 never completes a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shared shift strobe; one bit per lane is sampled when high |
| lane_din | input | 4 | Serial data, one bit per lane |
| lane_mask | input | 4 | Per-lane enable; 0 forces the lane's segment to zero |
| rd_en | input | 1 | Host read request |
| rd_data | output | 32 | Registered read data, valid one cycle after a read |
| fifo_empty | output | 1 | FIFO holds no words |
| ovf_flag | output | 1 | Sticky flag, set when a word is dropped |
| ovf_clear | input | 1 | Host clear of ovf_flag |
| frame_words | input | 20 | Number of words per frame; 0 disables frame completion |
| word_count | output | 20 | Words assembled in the current frame |
| frame_count | output | 16 | Completed frames, wrapping |
| frame_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bench checks the bit order within a segment and the lane-to-byte mapping. A design that swaps either one returns words whose bytes are reversed or in the wrong slots. It also checks the exact cycle in which a finished word becomes visible, and that idle strobe gaps are ignored; an off-by-one bit counter shows up there as a shifted word or a flag that changes early. It fills the FIFO to exactly its depth and then sends one more word. This catches an implementation that drops at the wrong depth, overwrites stored words, or lets the overflow flag lapse. Finally, it reads the empty FIFO, counts a three-word frame, and runs randomly masked streams with random gaps.

// File: rtl/pld_pkg.sv
package pld_pkg;

    localparam int unsigned PLD_LANES  = 4;
    localparam int unsigned PLD_SEG_W  = 8;
    localparam int unsigned PLD_DEPTH  = 16;
    localparam int unsigned PLD_CNT_W  = 20;
    localparam int unsigned PLD_FRM_W  = 16;

    // Event produced when an assembled word meets the FIFO
    typedef struct packed {
        logic push;
        logic drop;
    } wr_ev_t;

    // Low bit of a lane's segment inside the output word
    function automatic int unsigned seg_lo(input int unsigned lane, input int unsigned seg_w);
        return lane * seg_w;
    endfunction

endpackage

// File: rtl/pld_bit_timer.sv
module pld_bit_timer #(
    parameter int unsigned SEG_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    output logic seg_last
);
    localparam int unsigned BW = (SEG_W > 1) ? $clog2(SEG_W) : 1;
    localparam logic [BW-1:0] LAST = BW'(SEG_W - 1);

    logic [BW-1:0] bit_idx;

    assign seg_last = shift_en && (bit_idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx <= '0;
        end else if (shift_en) begin
            bit_idx <= (bit_idx == LAST) ? '0 : bit_idx + BW'(1);
        end
    end
endmodule

// File: rtl/pld_lane.sv
module pld_lane #(
    parameter int unsigned SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    input  logic             lane_on,
    output logic [SEG_W-1:0] seg_next
);
    logic [SEG_W-1:0] sreg;

    // earliest bit migrates toward the MSB
    assign seg_next = {sreg[SEG_W-2:0], din & lane_on};

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (shift_en) begin
            sreg <= seg_next;
        end
    end
endmodule

// File: rtl/pld_word_fifo.sv
module pld_word_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic          do_wr;
    logic          do_rd;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            rp      <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == PMAX) ? '0 : wp + PW'(1);
            end
            if (do_rd) begin
                rd_data <= mem[rp];
                rp      <= (rp == PMAX) ? '0 : rp + PW'(1);
            end
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pld_frame_tracker.sv
module pld_frame_tracker #(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned FRM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_in,
    input  logic [CNT_W-1:0] frame_words,
    output logic [CNT_W-1:0] word_count,
    output logic [FRM_W-1:0] frame_count,
    output logic             frame_done
);
    logic [CNT_W-1:0] next_cnt;
    logic             closes;

    assign next_cnt = word_count + CNT_W'(1);
    assign closes   = (frame_words != '0) && (next_cnt == frame_words);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_count  <= '0;
            frame_count <= '0;
            frame_done  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (word_in) begin
                if (closes) begin
                    word_count  <= '0;
                    frame_count <= frame_count + FRM_W'(1);
                    frame_done  <= 1'b1;
                end else begin
                    word_count <= next_cnt;
                end
            end
        end
    end
endmodule

// File: rtl/pix_lane_deser.sv
module pix_lane_deser
    import pld_pkg::*;
#(
    parameter int unsigned LANES = PLD_LANES,
    parameter int unsigned SEG_W = PLD_SEG_W,
    parameter int unsigned DEPTH = PLD_DEPTH,
    parameter int unsigned CNT_W = PLD_CNT_W,
    parameter int unsigned FRM_W = PLD_FRM_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_en,
    input  logic [LANES-1:0]       lane_din,
    input  logic [LANES-1:0]       lane_mask,
    input  logic                   rd_en,
    output logic [LANES*SEG_W-1:0] rd_data,
    output logic                   fifo_empty,
    output logic                   ovf_flag,
    input  logic                   ovf_clear,
    input  logic [CNT_W-1:0]       frame_words,
    output logic [CNT_W-1:0]       word_count,
    output logic [FRM_W-1:0]       frame_count,
    output logic                   frame_done
);
    localparam int unsigned WORD_W = LANES * SEG_W;
    localparam int unsigned CW     = $clog2(DEPTH + 1);

    logic              seg_last;
    logic [WORD_W-1:0] assembled;
    logic [WORD_W-1:0] word_q;
    logic              word_vld;
    logic              fifo_full;
    logic [CW-1:0]     fifo_count;
    wr_ev_t            ev;

    pld_bit_timer #(.SEG_W(SEG_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .seg_last (seg_last)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pld_lane #(.SEG_W(SEG_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .shift_en (shift_en),
            .din      (lane_din[k]),
            .lane_on  (lane_mask[k]),
            .seg_next (assembled[seg_lo(k, SEG_W) +: SEG_W])
        );
    end

    // latch the finished word; FIFO takes it on the following edge
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= seg_last;
            if (seg_last) begin
                word_q <= assembled;
            end
        end
    end

    always_comb begin
        ev.push = word_vld && !fifo_full;
        ev.drop = word_vld && fifo_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
        end else if (ev.drop) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clear) begin
            ovf_flag <= 1'b0;
        end
    end

    pld_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ev.push),
        .wr_data (word_q),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .count   (fifo_count)
    );

    pld_frame_tracker #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .word_in     (word_vld),
        .frame_words (frame_words),
        .word_count  (word_count),
        .frame_count (frame_count),
        .frame_done  (frame_done)
    );
endmodule

// File: rtl/pld_checker.sv
module pld_checker #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rd_en,
    input logic [WORD_W-1:0]          rd_data,
    input logic                       fifo_empty,
    input logic                       fifo_full,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input logic                       ovf_flag,
    input logic                       ovf_clear,
    input logic                       word_vld,
    input logic                       frame_done
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> fifo_empty && !ovf_flag && !frame_done);

    p_push_visible_r4: assert property (@(posedge clk) disable iff (rst)
        word_vld && !fifo_full |=> !fifo_empty);

    p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
        rd_en && fifo_empty |=> $stable(rd_data));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !ovf_clear |=> ovf_flag);

    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(word_vld && fifo_full));

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_clear && !(word_vld && fifo_full) |=> !ovf_flag);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

bind pix_lane_deser pld_checker #(.WORD_W(LANES*SEG_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_count (fifo_count),
    .ovf_flag   (ovf_flag),
    .ovf_clear  (ovf_clear),
    .word_vld   (word_vld),
    .frame_done (frame_done)
);

// File: tb/sim_pix_lane_deser.sv
module sim_pix_lane_deser;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shift_en = 1'b0;
    logic [3:0]  lane_din = '0;
    logic [3:0]  lane_mask = 4'hF;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        fifo_empty;
    logic        ovf_flag;
    logic        ovf_clear = 1'b0;
    logic [19:0] frame_words = '0;
    logic [19:0] word_count;
    logic [15:0] frame_count;
    logic        frame_done;

    int n_chk = 0;
    int n_err = 0;
    int pulses = 0;
    logic [31:0] expq [$];

    always #4 clk = ~clk;

    pix_lane_deser u0 (
        .clk(clk), .rst(rst), .shift_en(shift_en), .lane_din(lane_din),
        .lane_mask(lane_mask), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .ovf_flag(ovf_flag), .ovf_clear(ovf_clear),
        .frame_words(frame_words), .word_count(word_count),
        .frame_count(frame_count), .frame_done(frame_done)
    );

    always @(negedge clk) if (!rst && frame_done) pulses++;

    function automatic logic [31:0] expect_word(input logic [31:0] w, input logic [3:0] m);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = m[k] ? w[8*k +: 8] : 8'h00;
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expq.delete();
        pulses = 0;
    endtask

    // Shifts one word; returns at the negedge right after the eighth bit's edge.
    task automatic send_word(input logic [31:0] w, input logic [3:0] m, input int gap_max);
        lane_mask = m;
        for (int i = 0; i < 8; i++) begin
            if (gap_max > 0) begin
                int g = int'($urandom % (gap_max + 1));
                for (int j = 0; j < g; j++) begin
                    shift_en = 1'b0;
                    lane_din = 4'($urandom);
                    @(negedge clk);
                end
            end
            shift_en = 1'b1;
            for (int k = 0; k < 4; k++) lane_din[k] = w[8*k + 7 - i];
            @(negedge clk);
        end
        shift_en = 1'b0;
        if (expq.size() < DEPTH) expq.push_back(expect_word(w, m));
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic read_chk(input string req);
        logic [31:0] e;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        e = expq.pop_front();
        chk(req, 64'(rd_data), 64'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20061));
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 empty", 64'(fifo_empty), 64'd1);
        chk("R1 ovf", 64'(ovf_flag), 64'd0);
        chk("R1 counts", {word_count, frame_count, frame_done}, 64'd0);
        chk("R1 rd_data", 64'(rd_data), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2 lane/byte placement, R4 write timing
        send_word(32'h81F03CA5, 4'hF, 0);
        chk("R4 empty after 8th edge", 64'(fifo_empty), 64'd1);
        @(negedge clk);
        chk("R4 word visible", 64'(fifo_empty), 64'd0);
        read_chk("R2 lane mapping");
        chk("R6 drained", 64'(fifo_empty), 64'd1);

        // R6 empty read holds data
        held = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R6 empty read", 64'(rd_data), 64'(held));

        // R3 masked lanes, R4 idle gaps
        send_word(32'hDEADBEEF, 4'b0101, 0);
        settle();
        read_chk("R3 mask zeros");
        send_word(32'h12345678, 4'hF, 3);
        settle();
        read_chk("R4 gaps ignored");
        // back-to-back words
        send_word(32'hCAFEF00D, 4'hF, 0);
        send_word(32'h0BADC0DE, 4'b1110, 0);
        settle();
        read_chk("R5 order first");
        read_chk("R5 order second");

        // R5/R7/R8 overflow
        do_reset();
        for (int n = 0; n < DEPTH; n++) send_word(32'h01010101 * (n + 1), 4'hF, 0);
        settle();
        chk("R7 no ovf at depth", 64'(ovf_flag), 64'd0);
        send_word(32'hFFFFFFFF, 4'hF, 0);
        settle();
        chk("R7 ovf set", 64'(ovf_flag), 64'd1);
        for (int n = 0; n < DEPTH; n++) read_chk("R5 R7 stored words");
        chk("R5 empty after depth", 64'(fifo_empty), 64'd1);
        chk("R7 ovf sticky", 64'(ovf_flag), 64'd1);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
        chk("R8 ovf cleared", 64'(ovf_flag), 64'd0);

        // R9 frame counting
        do_reset();
        frame_words = 20'd3;
        send_word(32'h11111111, 4'hF, 0);
        send_word(32'h22222222, 4'hF, 0);
        settle();
        chk("R9 word_count", 64'(word_count), 64'd2);
        chk("R9 no pulse yet", 64'(pulses), 64'd0);
        send_word(32'h33333333, 4'hF, 0);
        settle();
        chk("R9 count wraps", 64'(word_count), 64'd0);
        chk("R9 frame_count", 64'(frame_count), 64'd1);
        chk("R9 one pulse", 64'(pulses), 64'd1);
        for (int n = 0; n < 3; n++) read_chk("R9 words kept");

        // random streams
        do_reset();
        frame_words = 20'd0;
        for (int n = 0; n < 48; n++) begin
            send_word($urandom, 4'($urandom), int'($urandom % 3));
            if (n % 8 == 7) begin
                settle();
                while (expq.size() > 0) read_chk("R2 R3 R5 random");
                chk("R9 disabled frame", 64'(frame_count), 64'd0);
            end
        end
        chk("R7 random no ovf", 64'(ovf_flag), 64'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule